// File: doc/BRIEF.md
# Eight-Port Self-Steering Multistage Switch Fabric

This block moves fixed-width packets from N source ports to N destination ports through a chain of log2(N) switching stages. Each stage has N/2 two-by-two switching elements, and the lines are perfectly shuffled before each stage. Every packet carries a valid flag, a destination tag and a payload. Each stage steers the packet toward its element's upper or lower output using one bit of the destination tag, starting from the most significant bit. No routing table and no central controller are involved.

The fabric is blocking. Two packets can need the same internal link even when their final ports differ. When this happens the element forwards the packet on its upper input and drops the packet on its lower input. Every dropped packet is reported in a blocked vector that is indexed by source port. The delivered packets and the blocked vector are registered together and appear one clock after the inputs are sampled. The block has no buffering and no retry. The surrounding logic decides whether to present a blocked packet again.

Top module: `omega_fabric`

## Requirements
- R1: The outputs `out_valid`, `out_dest`, `out_data` and `blocked` reflect the inputs sampled at the previous rising clock edge. An active-low asynchronous `rst_n` drives `out_valid` and `blocked` to all zeros.
- R2: When `out_valid[p]` is 1, `out_dest` field p (bits p*3+2..p*3) equals p. `out_data` field p (bits p*16+15..p*16) is then the unmodified payload of the source that was routed there.
- R3: Before each stage, line i moves to line rotl1(i), a 1-bit left rotation of the 3-bit index. Element j owns lines 2j (upper) and 2j+1 (lower). Stage k (k = 0, 1, 2) reads destination bit 2−k. A bit value of 0 selects the upper output line 2j, and a value of 1 selects the lower output line 2j+1.
- R4: When both inputs of an element are valid and select the same output, the packet on the upper input passes. The packet on the lower input is dropped.
- R5: Each valid input in a cycle is either delivered on exactly one output or flagged in `blocked`, never both. The count of set `out_valid` bits plus set `blocked` bits equals the count of set `in_valid` bits.
- R6: An input with `in_valid` low never blocks another packet, never appears on an output and never sets its `blocked` bit.
- R7: `blocked[i]` is 1 exactly when the packet from source i was dropped at some stage.
- R8: Two packets with different destination tags can still collide inside the fabric. For example, source 0 to port 0 and source 4 to port 1 meet in stage 0, and source 4 is reported blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Per-source packet present flag |
| in_dest | input | 24 | Per-source destination tag, 3 bits each, source i at bits 3i+2..3i |
| in_data | input | 128 | Per-source payload, 16 bits each, source i at bits 16i+15..16i |
| out_valid | output | 8 | Per-port delivered flag, registered |
| out_dest | output | 24 | Per-port destination tag of the delivered packet, registered |
| out_data | output | 128 | Per-port delivered payload, registered |
| blocked | output | 8 | Per-source dropped flag, registered |

## Verification
Several properties are checked on every cycle. A delivered packet always sits on the port named by its own tag. Delivered plus blocked always equals the previous cycle's valid count. An idle source is never flagged. Inside each element, a same-direction collision always favours the upper input. Only the bench's scenarios can show which source loses a given collision after the shuffle wiring and the MSB-first bit order act together. The same holds for whether known conflict-free patterns such as the identity, cyclic shifts and sparse crossings pass intact, and for the one-cycle latency and the asynchronous clear.

// File: rtl/omega_pkg.sv
package omega_pkg;

   // Perfect shuffle: rotate a BITS-wide line index left by one place.
   function automatic int unsigned rotl1(input int unsigned idx, input int unsigned bits);
      int unsigned msk;
      msk = (32'd1 << bits) - 32'd1;
      return ((idx << 1) | (idx >> (bits - 1))) & msk;
   endfunction

endpackage

// File: rtl/omega_elem.sv
// One 2x2 switching element. Line word layout: {vld, src[LG], dst[LG], dat[W]}.
module omega_elem #(
   parameter int LG  = 3,
   parameter int W   = 16,
   parameter int BIT = 2,
   localparam int LW = 1 + 2*LG + W
) (
   input  logic [LW-1:0] up_i,
   input  logic [LW-1:0] lo_i,
   output logic [LW-1:0] up_o,
   output logic [LW-1:0] lo_o,
   output logic          lo_lost
);
   localparam int VB = LW - 1;
   localparam int DB = W + BIT;

   initial begin
      if (BIT < 0 || BIT >= LG) $error("omega_elem: BIT out of range");
   end

   logic up_v, lo_v, up_dir, lo_dir;
   assign up_v   = up_i[VB];
   assign lo_v   = lo_i[VB];
   assign up_dir = up_i[DB];
   assign lo_dir = lo_i[DB];

   always_comb begin
      up_o    = '0;
      lo_o    = '0;
      lo_lost = 1'b0;
      if (up_v) begin
         if (up_dir) lo_o = up_i;
         else        up_o = up_i;
      end
      if (lo_v) begin
         if (lo_dir) begin
            if (lo_o[VB]) lo_lost = 1'b1;
            else          lo_o    = lo_i;
         end else begin
            if (up_o[VB]) lo_lost = 1'b1;
            else          up_o    = lo_i;
         end
      end
   end

   // R4: on a same-direction collision the upper packet leaves, the lower is lost
   always_comb begin
      if (!$isunknown({up_i, lo_i}) && up_v && lo_v && (up_dir == lo_dir)) begin
         a_r4_upper_wins: assert (lo_lost && ((up_dir ? lo_o : up_o) == up_i))
            else $error("a_r4_upper_wins violated");
      end
   end

endmodule

// File: rtl/omega_stage.sv
// One stage: perfect shuffle of the lines, then N/2 elements steering on bit BIT.
module omega_stage
   import omega_pkg::*;
#(
   parameter int N   = 8,
   parameter int LG  = 3,
   parameter int W   = 16,
   parameter int BIT = 2,
   localparam int LW = 1 + 2*LG + W
) (
   input  logic [N*LW-1:0] lines_i,
   output logic [N*LW-1:0] lines_o,
   output logic [N-1:0]    lost_src
);
   localparam int NE = N / 2;
   localparam int SB = W + LG;  // lsb of the source field

   logic [LW-1:0] shuf [N];
   logic [NE-1:0] lost;

   for (genvar i = 0; i < N; i++) begin : g_shuf
      assign shuf[rotl1(i, LG)] = lines_i[i*LW +: LW];
   end

   for (genvar j = 0; j < NE; j++) begin : g_elem
      omega_elem #(.LG(LG), .W(W), .BIT(BIT)) u_elem (
         .up_i    (shuf[2*j]),
         .lo_i    (shuf[2*j+1]),
         .up_o    (lines_o[(2*j)*LW +: LW]),
         .lo_o    (lines_o[(2*j+1)*LW +: LW]),
         .lo_lost (lost[j])
      );
   end

   always_comb begin
      lost_src = '0;
      for (int j = 0; j < NE; j++) begin
         if (lost[j]) lost_src[shuf[2*j+1][SB +: LG]] = 1'b1;
      end
   end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
   parameter int N = 8,
   parameter int W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          in_valid,
   input  logic [N*$clog2(N)-1:0] in_dest,
   input  logic [N*W-1:0]        in_data,
   output logic [N-1:0]          out_valid,
   output logic [N*$clog2(N)-1:0] out_dest,
   output logic [N*W-1:0]        out_data,
   output logic [N-1:0]          blocked
);
   localparam int LG = $clog2(N);
   localparam int LW = 1 + 2*LG + W;

   if (N < 2 || (1 << LG) != N) begin : g_bad_n
      $error("omega_fabric: N must be a power of two and at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("omega_fabric: W must be positive");
   end

   logic [N*LW-1:0] chain  [LG+1];
   logic [N-1:0]    lost_k [LG];
   logic [N-1:0]    lost_all;

   for (genvar i = 0; i < N; i++) begin : g_src
      assign chain[0][i*LW +: LW] =
         {in_valid[i], LG'(i), in_dest[i*LG +: LG], in_data[i*W +: W]};
   end

   for (genvar k = 0; k < LG; k++) begin : g_stage
      omega_stage #(.N(N), .LG(LG), .W(W), .BIT(LG-1-k)) u_stage (
         .lines_i  (chain[k]),
         .lines_o  (chain[k+1]),
         .lost_src (lost_k[k])
      );
   end

   always_comb begin
      lost_all = '0;
      for (int k = 0; k < LG; k++) lost_all |= lost_k[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= '0;
         out_dest  <= '0;
         out_data  <= '0;
         blocked   <= '0;
      end else begin
         for (int p = 0; p < N; p++) begin
            out_valid[p]           <= chain[LG][p*LW + LW - 1];
            out_dest[p*LG +: LG]   <= chain[LG][p*LW + W +: LG];
            out_data[p*W +: W]     <= chain[LG][p*LW +: W];
         end
         blocked <= lost_all;
      end
   end

   // R2: a delivered packet always sits on the port named by its tag
   for (genvar p = 0; p < N; p++) begin : g_chk
      a_r2_port_match: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[p] |-> (out_dest[p*LG +: LG] == LG'(p)))
         else $error("a_r2_port_match violated");
   end

   // R5: every valid input is delivered or blocked, exactly once
   a_r5_conserve: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($countones(out_valid) + $countones(blocked)) == $countones($past(in_valid))))
      else $error("a_r5_conserve violated");

   // R6: an idle source is never reported blocked
   a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((blocked & ~$past(in_valid)) == '0))
      else $error("a_r6_idle_clear violated");

endmodule

// File: tb/sim_omega_fabric.sv
`timescale 1ns/1ps
module sim_omega_fabric;
   localparam int N = 8;
   localparam int W = 16;
   localparam int LG = 3;
   localparam int NV = 9;

   typedef struct packed {
      logic [7:0]  v;
      logic [23:0] d;
      logic [7:0]  b;
   } vec_t;

   // valid mask, destinations (octal digit i = source i), hand-derived blocked mask
   localparam vec_t TBL [NV] = '{
      '{8'hFF, 24'o76543210, 8'h00},  // identity
      '{8'h11, 24'o00000000, 8'h10},  // src0,src4 -> port0
      '{8'h11, 24'o00010000, 8'h10},  // src0->0, src4->1: internal clash (R8)
      '{8'hFF, 24'o73516240, 8'hF0},  // bit reversal
      '{8'hFF, 24'o07654321, 8'h00},  // cyclic shift by one
      '{8'h08, 24'o00005000, 8'h00},  // single packet
      '{8'h00, 24'o76543210, 8'h00},  // all idle
      '{8'h62, 24'o00600170, 8'h20},  // idle src2 shares direction (R6)
      '{8'h81, 24'o00000007, 8'h00}   // corner crossing
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   in_valid = '0;
   logic [N*LG-1:0] in_dest = '0;
   logic [N*W-1:0] in_data = '0;
   logic [N-1:0]   out_valid;
   logic [N*LG-1:0] out_dest;
   logic [N*W-1:0] out_data;
   logic [N-1:0]   blocked;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   omega_fabric #(.N(N), .W(W)) u0 (
      .clk, .rst_n, .in_valid, .in_dest, .in_data,
      .out_valid, .out_dest, .out_data, .blocked
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pay(input int tag, input int s);
      return {tag[7:0], 5'd0, s[2:0]};
   endfunction

   // Independent model of R3/R4: shuffle, MSB-first steering, upper input wins
   task automatic model(input logic [7:0] v, input logic [23:0] d,
                        output logic [7:0] ev, output logic [23:0] esrc, output logic [7:0] eb);
      int pos [8];
      int sp [8];
      int tgt [8];
      bit alive [8];
      bit claim [8];
      ev = '0; esrc = '0; eb = '0;
      for (int s = 0; s < 8; s++) begin
         alive[s] = v[s];
         pos[s] = s;
      end
      for (int k = 0; k < 3; k++) begin
         for (int l = 0; l < 8; l++) claim[l] = 1'b0;
         for (int s = 0; s < 8; s++) begin
            sp[s]  = ((pos[s] << 1) | (pos[s] >> 2)) & 7;
            tgt[s] = (sp[s] & 6) | int'(d[s*3 + (2-k)]);
         end
         for (int pass = 0; pass < 2; pass++) begin
            for (int s = 0; s < 8; s++) begin
               if (alive[s] && (sp[s] & 1) == pass) begin
                  if (claim[tgt[s]]) begin
                     alive[s] = 1'b0;
                     eb[s] = 1'b1;
                  end else begin
                     claim[tgt[s]] = 1'b1;
                     pos[s] = tgt[s];
                  end
               end
            end
         end
      end
      for (int s = 0; s < 8; s++) begin
         if (alive[s]) begin
            ev[pos[s]] = 1'b1;
            esrc[pos[s]*3 +: 3] = 3'(s);
         end
      end
   endtask

   task automatic drive(input logic [7:0] v, input logic [23:0] d, input int tag);
      in_valid = v;
      in_dest  = d;
      for (int s = 0; s < N; s++) in_data[s*W +: W] = pay(tag, s);
   endtask

   task automatic compare(input int t, input logic [7:0] v, input logic [23:0] d, input logic [7:0] tb_b);
      logic [7:0]  ev;
      logic [23:0] esrc;
      logic [7:0]  eb;
      model(v, d, ev, esrc, eb);
      chk(eb == tb_b, $sformatf("R4 R7 table/model agreement vec %0d", t), {24'd0, eb}, {24'd0, tb_b});
      chk(blocked == eb, $sformatf("R7 blocked vec %0d", t), {24'd0, blocked}, {24'd0, eb});
      chk(($countones(out_valid) + $countones(blocked)) == $countones(v),
          $sformatf("R5 conservation vec %0d", t),
          $countones(out_valid) + $countones(blocked), $countones(v));
      for (int p = 0; p < N; p++) begin
         chk(out_valid[p] == ev[p], $sformatf("R3 valid vec %0d port %0d", t, p),
             {31'd0, out_valid[p]}, {31'd0, ev[p]});
         if (ev[p]) begin
            chk(out_dest[p*3 +: 3] == 3'(p), $sformatf("R2 dest vec %0d port %0d", t, p),
                {29'd0, out_dest[p*3 +: 3]}, p);
            chk(out_data[p*W +: W] == pay(t, int'(esrc[p*3 +: 3])),
                $sformatf("R2 payload vec %0d port %0d", t, p),
                {16'd0, out_data[p*W +: W]}, {16'd0, pay(t, int'(esrc[p*3 +: 3]))});
         end
      end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      // R1: reset holds outputs clear even with traffic at the inputs
      drive(8'hFF, 24'o76543210, 1);
      repeat (3) @(negedge clk);
      chk(out_valid == '0, "R1 reset out_valid", {24'd0, out_valid}, 0);
      chk(blocked == '0, "R1 reset blocked", {24'd0, blocked}, 0);
      drive(8'h00, 24'o0, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector walk: drive at a falling edge, capture on the rising edge, check at the next fall
      for (int t = 0; t < NV; t++) begin
         drive(TBL[t].v, TBL[t].d, t);
         @(negedge clk);
         compare(t, TBL[t].v, TBL[t].d, TBL[t].b);
      end

      // R8: distinct destinations, internal collision, lower source loses
      drive(8'h11, 24'o00010000, 20);
      @(negedge clk);
      chk(blocked == 8'h10, "R8 internal clash blocks source 4", {24'd0, blocked}, 32'h10);
      chk(out_valid == 8'h01, "R8 source 0 still reaches port 0", {24'd0, out_valid}, 32'h01);

      // R1: one-cycle latency; output unchanged before the capturing edge
      drive(8'h00, 24'o0, 21);
      @(negedge clk);
      drive(8'h08, 24'o00005000, 22);
      @(posedge clk);
      #1;
      chk(out_valid == 8'h20, "R1 output after one edge", {24'd0, out_valid}, 32'h20);
      @(negedge clk);
      drive(8'h01, 24'o00000003, 23);
      #1;
      chk(out_valid == 8'h20, "R1 no change between edges", {24'd0, out_valid}, 32'h20);

      // R1: asynchronous reset clears mid-cycle
      #1 rst_n = 1'b0;
      #1;
      chk(out_valid == '0 && blocked == '0, "R1 async clear",
          {16'd0, out_valid, blocked}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(8'h11, 24'o00000000, 24);
      @(negedge clk);
      chk(blocked == 8'h10 && out_valid == 8'h01, "R4 upper wins after reset",
          {16'd0, out_valid, blocked}, 32'h0110);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule